// File: doc/BRIEF.md
# SDRAM Page-Aware Address Sequencer

This block sits between a memory request source and the address/control pins of up to four SDRAM regions. A request carries a system byte address, a region number, a read/write flag and a flag asking that the row be closed after the access. The block maps the address onto the multiplexed address pins and the internal-bank pins. The map depends on the column width and the internal bank count set for that region. The block keeps a record of the open row in every internal bank of every region. A request that finds its row already open goes straight to the column phase. Otherwise the block issues a precharge if another row is open in that bank, then a row phase, then the column phase.

Requests are taken one at a time through a valid/ready handshake. A single-cycle done pulse follows the cycle in which the column phase is driven. For writes, an indicator marks the column phase as a single-beat transfer.

Top module: `sdram_page_seq`

## Requirements
- R1: While an access is in progress exactly one bit of `mem_cs` is high: bit n for region n. When the block is idle, `mem_cs`, `mem_cmd`, `mem_ba`, `mem_addr` and `mem_single` are all zero.
- R2: Region n takes its column width from `cfg_col_sel[2n+1:2n]`, where codes 0, 1, 2 and 3 select 8, 9, 10 and 11 bits. In the column phase, `mem_addr[k]` = address bit 2+k for every k below both the width and 10. `mem_addr[11]` = address bit 12 when the width is 11 and 0 otherwise. Unused column pins and `mem_addr[12]` are 0.
- R3: In the column phase, `mem_addr[10]` carries the request's close flag rather than an address bit.
- R4: In the row phase, `mem_addr[7:0]` = address bits 21..14. `mem_addr[12:8]` are filled in ascending order, first from address bits 3+W through 13 and then from bits 22 upward, leaving out the BA1 source bit in four-bank mode. W is the column width.
- R5: `mem_ba[0]` = address bit 2+W. `mem_ba[1]` = address bit 14+W when `cfg_four_bank[n]` is 1, and 0 in two-bank mode. The same bank value is driven in every phase of the access.
- R6: When the addressed bank holds an open row equal to the requested row, the first phase after acceptance is the column phase (`mem_cmd`=3).
- R7: When the addressed bank has no open row, the row phase (`mem_cmd`=2) comes first, followed by the column phase in the next cycle.
- R8: When the addressed bank holds a different open row, a precharge phase comes first (`mem_cmd`=1, `mem_addr` all zero). It is followed by the row phase and then the column phase.
- R9: `done` is high for exactly the one cycle after the column phase. `req_ready` is high only when idle, and a request is accepted when `req_valid` and `req_ready` are both high at a clock edge.
- R10: `mem_single` is high during the column phase of a write and low for a read.
- R11: A column phase issued with the close flag set leaves that bank with no open row, so the next access to it takes the R7 path.
- R12: Open rows are tracked separately for each region and each internal bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_col_sel | input | 2*N_REG | Column width code per region |
| cfg_four_bank | input | N_REG | Four internal banks per region when 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | ADDR_W | System byte address |
| req_region | input | $clog2(N_REG) | Target region |
| req_write | input | 1 | Write request |
| req_close | input | 1 | Close row after column phase |
| done | output | 1 | One-cycle completion pulse |
| mem_cmd | output | 2 | Phase: 0 idle, 1 precharge, 2 row, 3 column |
| mem_addr | output | 13 | Multiplexed address pins |
| mem_ba | output | 2 | Internal bank pins |
| mem_cs | output | N_REG | Region selects, active high |
| mem_single | output | 1 | Single-beat column transfer |

## Verification
The bench sweeps all four column widths against both bank counts, and each region gets its own combination of the two. Each region receives an access to an empty bank, a same-row access, an access to a different row in the same bank, and an access to another bank with the close flag set. It also receives a repeat access to the closed bank and a return to the first bank. These tell apart the precharge, row and hit paths, show that the close flag releases the row, and expose any misplaced pin bit as the width moves the bank and row bits. A final access reuses one fixed address in every region, so rows leaking between regions appear as unexpected hits.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int MA_W = 13;
  localparam int BA_W = 2;
  localparam int MAX_BANKS = 4;
  localparam int PRE_PIN = 10;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_ROW  = 2'd2,
    CMD_COL  = 2'd3
  } cmd_e;
endpackage

// File: rtl/sps_addr_map.sv
module sps_addr_map
  import sps_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        col_sel,
  input  logic              four_bank,
  output logic [MA_W-1:0]   row_ma,
  output logic [MA_W-1:0]   col_ma,
  output logic [BA_W-1:0]   bank
);
  localparam int TOP_BIT = 27;

  // column word address starts at byte bit 2; pin 10 left free for the flag
  always_comb begin
    int cw;
    cw = 8 + int'(col_sel);
    col_ma = '0;
    for (int k = 0; k < 10; k++) begin
      if (k < cw) col_ma[k] = addr[2+k];
    end
    if (cw == 11) col_ma[11] = addr[12];
  end

  // bank pins sit just above the column, and above row bit 21 in four-bank mode
  always_comb begin
    int cw;
    cw = 8 + int'(col_sel);
    bank[0] = addr[2+cw];
    bank[1] = four_bank ? addr[14+cw] : 1'b0;
  end

  // row: fixed low byte, upper pins gathered from what column and bank leave
  always_comb begin
    int cw;
    logic [3:0] pos;
    cw = 8 + int'(col_sel);
    row_ma = '0;
    row_ma[7:0] = addr[21:14];
    pos = 4'd8;
    for (int b = 11; b <= 13; b++) begin
      if (b >= 3 + cw) begin
        row_ma[pos] = addr[b];
        pos = pos + 4'd1;
      end
    end
    for (int b = 22; b <= TOP_BIT; b++) begin
      if (!(four_bank && (b == 14 + cw)) && (pos <= 4'd12)) begin
        row_ma[pos] = addr[b];
        pos = pos + 4'd1;
      end
    end
  end

  initial begin
    if (ADDR_W < TOP_BIT + 1) $error("ADDR_W too small for the pin map");
  end
endmodule

// File: rtl/sps_row_table.sv
module sps_row_table
  import sps_pkg::*;
#(
  parameter int N_REG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    look_idx,
  input  logic [MA_W-1:0]     look_row,
  output logic                look_open,
  output logic                look_hit,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [MA_W-1:0]     wr_row
);
  localparam int ENTRIES = N_REG * MAX_BANKS;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [MA_W-1:0]    row_q [ENTRIES];

  always_comb begin
    vld_d = vld_q;
    if (set_en) vld_d[wr_idx] = 1'b1;
    if (clr_en) vld_d[wr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_row
    logic row_en;
    assign row_en = set_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (row_en) row_q[e] <= wr_row;
    end
  end

  assign look_open = vld_q[look_idx];
  assign look_hit  = vld_q[look_idx] && (row_q[look_idx] == look_row);

  AST_OPEN_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> vld_q[$past(wr_idx)]); // R7
  AST_SHUT_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !vld_q[$past(wr_idx)]); // R11
  AST_ONE_ENTRY_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q ^ $past(vld_q)) <= 1); // R12
endmodule

// File: rtl/sps_seq.sv
module sps_seq
  import sps_pkg::*;
#(
  parameter int N_REG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [REG_W-1:0]    req_region,
  input  logic                req_write,
  input  logic                req_close,
  input  logic [MA_W-1:0]     map_row,
  input  logic [MA_W-1:0]     map_col,
  input  logic [BA_W-1:0]     map_bank,
  input  logic                look_open,
  input  logic                look_hit,
  output logic                set_en,
  output logic                clr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [MA_W-1:0]     wr_row,
  output logic                done,
  output logic [1:0]          mem_cmd,
  output logic [MA_W-1:0]     mem_addr,
  output logic [BA_W-1:0]     mem_ba,
  output logic [N_REG-1:0]    mem_cs,
  output logic                mem_single
);
  localparam int REG_W = $clog2(N_REG);
  localparam int IDX_W = REG_W + BA_W;

  cmd_e state_q, state_d;
  logic accept;
  logic [REG_W-1:0] reg_q;
  logic [BA_W-1:0]  bank_q;
  logic [MA_W-1:0]  row_q, col_q;
  logic             wr_q, close_q, done_q;

  assign req_ready = (state_q == CMD_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CMD_IDLE: if (accept) begin
        if (look_hit)       state_d = CMD_COL;
        else if (look_open) state_d = CMD_PRE;
        else                state_d = CMD_ROW;
      end
      CMD_PRE: state_d = CMD_ROW;
      CMD_ROW: state_d = CMD_COL;
      CMD_COL: state_d = CMD_IDLE;
      default: state_d = CMD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CMD_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == CMD_COL);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      reg_q   <= req_region;
      bank_q  <= map_bank;
      row_q   <= map_row;
      col_q   <= map_col;
      wr_q    <= req_write;
      close_q <= req_close;
    end
  end

  assign set_en = (state_q == CMD_ROW);
  assign clr_en = (state_q == CMD_COL) && close_q;
  assign wr_idx = {reg_q, bank_q};
  assign wr_row = row_q;
  assign done   = done_q;

  always_comb begin
    mem_cmd    = state_q;
    mem_addr   = '0;
    mem_ba     = '0;
    mem_cs     = '0;
    mem_single = 1'b0;
    if (state_q != CMD_IDLE) begin
      mem_ba = bank_q;
      for (int r = 0; r < N_REG; r++) begin
        if (reg_q == REG_W'(r)) mem_cs[r] = 1'b1;
      end
    end
    if (state_q == CMD_ROW) mem_addr = row_q;
    if (state_q == CMD_COL) begin
      mem_addr = col_q;
      mem_addr[PRE_PIN] = close_q;
      mem_single = wr_q;
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd != 2'd0) |-> $onehot0(mem_cs) && (mem_cs != '0)); // R1
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 2'd0) |-> (mem_cs == '0)); // R1
  AST_HIT_SKIPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && look_hit) |=> (mem_cmd == 2'd3)); // R6
  AST_ROW_THEN_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 2'd2) |=> (mem_cmd == 2'd3)); // R7
  AST_PRE_THEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 2'd1) |=> (mem_cmd == 2'd2)); // R8
  AST_DONE_AFTER_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 2'd3) |=> done && req_ready); // R9
  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_cmd != 2'd0) && ($past(mem_cmd) != 2'd0) && !$past(done)) |-> $stable(mem_ba)); // R5
  AST_SINGLE_IN_COL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_single |-> (mem_cmd == 2'd3)); // R10
endmodule

// File: rtl/sdram_page_seq.sv
module sdram_page_seq
  import sps_pkg::*;
#(
  parameter int N_REG  = 4,
  parameter int ADDR_W = 28
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*N_REG-1:0]        cfg_col_sel,
  input  logic [N_REG-1:0]          cfg_four_bank,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [$clog2(N_REG)-1:0]  req_region,
  input  logic                      req_write,
  input  logic                      req_close,
  output logic                      done,
  output logic [1:0]                mem_cmd,
  output logic [12:0]               mem_addr,
  output logic [1:0]                mem_ba,
  output logic [N_REG-1:0]          mem_cs,
  output logic                      mem_single
);
  localparam int REG_W = $clog2(N_REG);
  localparam int IDX_W = REG_W + BA_W;

  // reset asserts at once, releases on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [1:0]      sel_col;
  logic            sel_four;
  logic [MA_W-1:0] map_row, map_col, wr_row;
  logic [BA_W-1:0] map_bank;
  logic            look_open, look_hit, set_en, clr_en;
  logic [IDX_W-1:0] wr_idx;

  assign sel_col  = cfg_col_sel[2*req_region +: 2];
  assign sel_four = cfg_four_bank[req_region];

  sps_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .addr      (req_addr),
    .col_sel   (sel_col),
    .four_bank (sel_four),
    .row_ma    (map_row),
    .col_ma    (map_col),
    .bank      (map_bank)
  );

  sps_row_table #(.N_REG(N_REG)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .look_idx  ({req_region, map_bank}),
    .look_row  (map_row),
    .look_open (look_open),
    .look_hit  (look_hit),
    .set_en    (set_en),
    .clr_en    (clr_en),
    .wr_idx    (wr_idx),
    .wr_row    (wr_row)
  );

  sps_seq #(.N_REG(N_REG)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_region (req_region),
    .req_write  (req_write),
    .req_close  (req_close),
    .map_row    (map_row),
    .map_col    (map_col),
    .map_bank   (map_bank),
    .look_open  (look_open),
    .look_hit   (look_hit),
    .set_en     (set_en),
    .clr_en     (clr_en),
    .wr_idx     (wr_idx),
    .wr_row     (wr_row),
    .done       (done),
    .mem_cmd    (mem_cmd),
    .mem_addr   (mem_addr),
    .mem_ba     (mem_ba),
    .mem_cs     (mem_cs),
    .mem_single (mem_single)
  );
endmodule

// File: tb/sdram_page_seq_test.sv
module sdram_page_seq_test;
  localparam int NR = 4;
  localparam int AW = 28;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [2*NR-1:0] cfg_col_sel;
  logic [NR-1:0]   cfg_four_bank;
  logic req_valid, req_ready, req_write, req_close, done, mem_single;
  logic [AW-1:0] req_addr;
  logic [1:0] req_region, mem_cmd, mem_ba;
  logic [12:0] mem_addr;
  logic [NR-1:0] mem_cs;

  sdram_page_seq #(.N_REG(NR), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_col_sel(cfg_col_sel), .cfg_four_bank(cfg_four_bank),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_region(req_region), .req_write(req_write), .req_close(req_close),
    .done(done), .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_ba(mem_ba),
    .mem_cs(mem_cs), .mem_single(mem_single)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit          open_v [16];
  logic [12:0] open_r [16];

  function automatic logic [23:0] pack(bit rdy, bit dn, logic [1:0] c, logic [3:0] cs,
                                       logic [1:0] ba, bit s, logic [12:0] a);
    return {rdy, dn, c, cs, ba, s, a};
  endfunction

  function automatic logic [23:0] seen();
    return {req_ready, done, mem_cmd, mem_cs, mem_ba, mem_single, mem_addr};
  endfunction

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected pins from the requirement text
  function automatic logic [12:0] want_row(logic [27:0] a, int w, bit fb);
    logic [12:0] r;
    int n;
    r = '0;
    for (int i = 0; i < 8; i++) r[i] = a[14+i];
    n = 8;
    for (int b = 3 + w; b <= 13; b++) begin r[n] = a[b]; n++; end
    for (int b = 22; n < 13; b++) begin
      if (!(fb && b == 14 + w)) begin r[n] = a[b]; n++; end
    end
    return r;
  endfunction

  function automatic logic [12:0] want_col(logic [27:0] a, int w, bit cl);
    logic [12:0] c;
    c = '0;
    for (int i = 0; i < w && i < 10; i++) c[i] = a[2+i];
    if (w == 11) c[11] = a[12];
    c[10] = cl;
    return c;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) open_v[i] = 1'b0;
    chk("R1 R9 reset idle", seen(), pack(1, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic access(int rg, logic [27:0] a, bit wr, bit cl);
    int w;
    bit fb;
    logic [1:0] bk;
    logic [12:0] rw;
    logic [3:0] csv;
    int key;
    w  = 8 + int'(cfg_col_sel[2*rg +: 2]);
    fb = cfg_four_bank[rg];
    bk = {fb ? a[14+w] : 1'b0, a[2+w]};
    rw = want_row(a, w, fb);
    csv = 4'b0001 << rg;
    key = rg * 4 + int'(bk);
    @(negedge clk);
    chk("R9 ready while idle", {23'd0, req_ready}, 24'd1);
    req_addr = a; req_region = 2'(rg); req_write = wr; req_close = cl;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (open_v[key] && open_r[key] == rw) begin
      chk("R6 R12 hit goes to column", seen(), pack(0, 0, 3, csv, bk, wr, want_col(a, w, cl)));
    end else begin
      if (open_v[key]) begin
        chk("R8 precharge first", seen(), pack(0, 0, 1, csv, bk, 0, 0));
        @(negedge clk);
      end
      chk("R4 R5 R7 R11 row phase", seen(), pack(0, 0, 2, csv, bk, 0, rw));
      @(negedge clk);
      chk("R1 R2 R3 R10 column phase", seen(), pack(0, 0, 3, csv, bk, wr, want_col(a, w, cl)));
      open_v[key] = 1'b1;
      open_r[key] = rw;
    end
    if (cl) open_v[key] = 1'b0;
    @(negedge clk);
    chk("R9 done pulse", seen(), pack(1, 1, 0, 0, 0, 0, 0));
  endtask

  initial begin
    req_addr = '0; req_region = '0; req_write = 1'b0; req_close = 1'b0;
    req_valid = 1'b0; cfg_col_sel = '0; cfg_four_bank = '0;
    for (int cs = 0; cs < 4; cs++) begin
      for (int fb = 0; fb < 2; fb++) begin
        for (int r = 0; r < NR; r++) begin
          cfg_col_sel[2*r +: 2] = 2'((cs + r) % 4);
          cfg_four_bank[r] = 1'((fb + r) % 2);
        end
        do_reset();
        for (int r = 0; r < NR; r++) begin
          logic [27:0] a1, a2, a3;
          int w;
          w  = 8 + int'(cfg_col_sel[2*r +: 2]);
          a1 = 28'h9A53C64 + 28'h04172B0 * 28'(r + cs);
          a2 = a1 ^ 28'h0028000;
          a3 = a1 ^ (28'h1 << (2 + w));
          access(r, a1, 1'b0, 1'b0);
          access(r, a1 ^ 28'h8, 1'b1, 1'b0);
          access(r, a2, 1'b0, 1'b0);
          access(r, a3, 1'b0, 1'b1);
          access(r, a3, 1'b1, 1'b0);
          access(r, a2 ^ 28'h4, 1'b0, 1'b0);
          access(r, 28'h7B5D3E8, 1'b0, 1'b0);
        end
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule